// File: doc/BRIEF.md
# Carry-Save Multi-Operand Reducer

This block takes a parameterized number of unsigned operands and reduces them, using a tree of full-adder rows, to two vectors: a sum vector and a carry vector. Each operand is zero-extended to the output width. The two results add, modulo two to the output width, to the sum of all the operands. The block is purely combinational. A carry-propagate adder placed after it, outside this block, finishes the addition. Typical uses are a multi-input accumulator or the reduction stage of a multiplier.

The tree is built at elaboration from a schedule of levels. Each operand carries a depth, and every input starts at depth 0. At each level, only the operands whose depth is no greater than the level number take part. A level with fewer than three such operands builds nothing. The eligible operands are taken in order. Under the grouping strategy, groups of four go to a 4:2 compressor, made of two chained full-adder rows, while at least four remain. Groups of three then go to a 3:2 compressor, a single full-adder row. One or two leftovers pass to the next level untouched. Two constant outputs report how many full-adder rows the tree uses and the depth of its deepest surviving output.

Top module: `carry_save_reducer`

## Requirements
- R1: For every input, (sumOut + carryOut) mod 2^W equals the sum of all N operands, each zero-extended from OPW bits to W bits, mod 2^W.
- R2: When N is at least 3, bit 0 of carryOut is always 0, because every carry vector leaves a full-adder row shifted up one place with a zero inserted at bit 0.
- R3: When N is 0, sumOut and carryOut are both all zeros.
- R4: When N is 1, sumOut equals the zero-extended operand and carryOut is zero.
- R5: When N is 2, sumOut equals operand 0 and carryOut equals operand 1, each zero-extended, with no adder row built.
- R6: rowCount equals the number of full-adder rows in the tree, where a 3:2 compressor counts one row and a 4:2 compressor counts two. N=4 gives 2 under both strategies, and N=9 gives 7 under both.
- R7: treeDepth equals the larger depth of the two surviving vectors. A 3:2 output has depth one more than its deepest input, and a 4:2 output has depth two more. N=3 gives 1, and N=4 gives 2 under both strategies.
- R8: With PREFER_42 = 0, no 4:2 compressor is built. N=6 therefore gives treeDepth 3 with PREFER_42 = 0 and 4 with PREFER_42 = 1, and N=9 gives 4 and 5 respectively.
- R9: An operand waits until the level number reaches its depth. A level with fewer than three eligible operands builds nothing, and leftovers pass through. Under PREFER_42 = 1, N=5 gives rowCount 3 and treeDepth 3, and N=7 gives rowCount 5 and treeDepth 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | max(N,1)*OPW | Packed operands; operand j occupies bits [j*OPW +: OPW] |
| sumOut | output | W | Sum vector of the reduction |
| carryOut | output | W | Carry vector of the reduction |
| rowCount | output | 16 | Constant: number of full-adder rows in the tree |
| treeDepth | output | 16 | Constant: depth of the deepest surviving vector |

## Verification
Every result is due in the same cycle as its stimulus, because the block has no registers. rowCount and treeDepth are constants from elaboration onward. The bench changes the operand bus one time unit after a rising edge and reads every instance at the following falling edge, so the combinational tree has half a period to settle. Twenty instances, covering N from 0 to 9 under both strategies, share one operand bus, and each result is compared with sums and schedule figures that the bench computes on its own.

// File: rtl/cmpr_pkg.sv
package cmpr_pkg;

  localparam int MAX_OPERANDS = 64;
  localparam int POOL_MAX     = 3 * MAX_OPERANDS + 4;

  // Query selectors for whole-tree figures (used with k < 0)
  localparam int Q_OPS   = 0;
  localparam int Q_LEFT  = 1;
  localparam int Q_FIN0  = 2;
  localparam int Q_FIN1  = 3;
  localparam int Q_DEPTH = 4;
  localparam int Q_ROWS  = 5;

  // Per-compressor selectors (used with k >= 0)
  localparam int F_KIND  = 0;  // 3 or 4 inputs
  // F_KIND + 1 .. F_KIND + 4 : source vector ids of the inputs

  // Builds the level schedule and answers one question about it.
  // Vector ids: 0..n-1 are operands, n+2*op is the sum of compressor op,
  // n+2*op+1 its carry.
  function automatic int planQuery(input int n, input bit use42,
                                   input int k, input int field);
    int ids  [POOL_MAX];
    int dep  [POOL_MAX];
    int rdy  [POOL_MAX];
    int wt   [POOL_MAX];
    int nxt  [POOL_MAX];
    int cnt, rCnt, wCnt, nCnt, ops, rows, level, i, rem, grp, dMax, base, res;
    res = 0;
    cnt = n;
    ops = 0;
    rows = 0;
    level = 0;
    for (int j = 0; j < POOL_MAX; j++) begin
      ids[j] = j;
      dep[j] = 0;
      rdy[j] = 0;
      wt[j]  = 0;
      nxt[j] = 0;
    end
    while (cnt > 2) begin
      rCnt = 0;
      wCnt = 0;
      for (int j = 0; j < cnt; j++) begin
        if (dep[ids[j]] <= level) begin
          rdy[rCnt] = ids[j];
          rCnt++;
        end else begin
          wt[wCnt] = ids[j];
          wCnt++;
        end
      end
      if (rCnt >= 3) begin
        nCnt = 0;
        i = 0;
        while (i < rCnt) begin
          rem = rCnt - i;
          grp = (use42 && rem >= 4) ? 4 : ((rem >= 3) ? 3 : 0);
          if (grp == 0) begin
            for (int j = i; j < rCnt; j++) begin
              nxt[nCnt] = rdy[j];
              nCnt++;
            end
            i = rCnt;
          end else begin
            dMax = 0;
            for (int j = 0; j < grp; j++)
              if (dep[rdy[i+j]] > dMax) dMax = dep[rdy[i+j]];
            base = n + 2 * ops;
            if (ops == k) begin
              if (field == F_KIND) res = grp;
              else if (field >= 1 && field <= grp) res = rdy[i+field-1];
            end
            dep[base]     = dMax + grp - 2;
            dep[base + 1] = dMax + grp - 2;
            nxt[nCnt]     = base;
            nxt[nCnt + 1] = base + 1;
            nCnt += 2;
            ops++;
            rows += grp - 2;
            i += grp;
          end
        end
        for (int j = 0; j < wCnt; j++) begin
          nxt[nCnt] = wt[j];
          nCnt++;
        end
        for (int j = 0; j < nCnt; j++) ids[j] = nxt[j];
        cnt = nCnt;
      end
      level++;
    end
    if (k < 0) begin
      case (field)
        Q_OPS:   res = ops;
        Q_LEFT:  res = cnt;
        Q_FIN0:  res = (cnt > 0) ? ids[0] : 0;
        Q_FIN1:  res = (cnt > 1) ? ids[1] : 0;
        Q_DEPTH: begin
          if (cnt == 0)      res = 0;
          else if (cnt == 1) res = dep[ids[0]];
          else               res = (dep[ids[0]] > dep[ids[1]]) ? dep[ids[0]] : dep[ids[1]];
        end
        Q_ROWS:  res = rows;
        default: res = 0;
      endcase
    end
    return res;
  endfunction

endpackage

// File: rtl/cmpr_csa_row.sv
module cmpr_csa_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumV,
  output logic [W-1:0] carV
);
  logic [W-1:0] maj;

  assign sumV = inA ^ inB ^ inC;
  assign maj  = (inA & inB) | (inA & inC) | (inB & inC);
  // carries move up one column; the top carry drops out of the W-bit field
  assign carV = W'({maj, 1'b0});
endmodule

// File: rtl/cmpr_comp42.sv
module cmpr_comp42 #(
  parameter int W = 8
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  input  logic [W-1:0] inD,
  output logic [W-1:0] sumV,
  output logic [W-1:0] carV
);
  logic [W-1:0] firstSum;
  logic [W-1:0] firstCar;

  cmpr_csa_row #(.W(W)) u_rowFirst (
    .inA(inA), .inB(inB), .inC(inC),
    .sumV(firstSum), .carV(firstCar)
  );

  // the shifted carries of the first row are the carry-in of the second
  cmpr_csa_row #(.W(W)) u_rowSecond (
    .inA(firstSum), .inB(inD), .inC(firstCar),
    .sumV(sumV), .carV(carV)
  );
endmodule

// File: rtl/carry_save_reducer.sv
module carry_save_reducer
  import cmpr_pkg::*;
#(
  parameter int N         = 6,
  parameter int OPW       = 8,
  parameter int W         = 12,
  parameter bit PREFER_42 = 1'b1,
  localparam int IN_W     = ((N == 0) ? 1 : N) * OPW
) (
  input  logic [IN_W-1:0] opIn,
  output logic [W-1:0]    sumOut,
  output logic [W-1:0]    carryOut,
  output logic [15:0]     rowCount,
  output logic [15:0]     treeDepth
);
  localparam int NUM_OPS  = planQuery(N, PREFER_42, -1, Q_OPS);
  localparam int LEFT     = planQuery(N, PREFER_42, -1, Q_LEFT);
  localparam int FIN0     = planQuery(N, PREFER_42, -1, Q_FIN0);
  localparam int FIN1     = planQuery(N, PREFER_42, -1, Q_FIN1);
  localparam int DEPTH    = planQuery(N, PREFER_42, -1, Q_DEPTH);
  localparam int ROWS     = planQuery(N, PREFER_42, -1, Q_ROWS);
  localparam int EXT_SLOTS = (N == 0) ? 1 : N;

  assign rowCount  = 16'(ROWS);
  assign treeDepth = 16'(DEPTH);

  // zero-extend every operand to the working width
  logic [W-1:0] opExt [EXT_SLOTS];
  for (genvar j = 0; j < EXT_SLOTS; j++) begin : gExt
    assign opExt[j] = W'(opIn[j*OPW +: OPW]);
  end

  // one compressor per scheduled slot; inputs fetched by vector id
  for (genvar k = 0; k < NUM_OPS; k++) begin : gOp
    localparam int KIND = planQuery(N, PREFER_42, k, F_KIND);
    logic [W-1:0] inV [KIND];
    logic [W-1:0] sumV;
    logic [W-1:0] carV;

    for (genvar s = 0; s < KIND; s++) begin : gIn
      localparam int SRC = planQuery(N, PREFER_42, k, s + 1);
      if (SRC < N) begin : gFromOperand
        assign inV[s] = opExt[SRC];
      end else if (((SRC - N) % 2) == 0) begin : gFromSum
        assign inV[s] = gOp[(SRC - N) / 2].sumV;
      end else begin : gFromCarry
        assign inV[s] = gOp[(SRC - N) / 2].carV;
      end
    end

    if (KIND == 4) begin : gFour
      cmpr_comp42 #(.W(W)) u_comp (
        .inA(inV[0]), .inB(inV[1]), .inC(inV[2]), .inD(inV[3]),
        .sumV(sumV), .carV(carV)
      );
    end else begin : gThree
      cmpr_csa_row #(.W(W)) u_comp (
        .inA(inV[0]), .inB(inV[1]), .inC(inV[2]),
        .sumV(sumV), .carV(carV)
      );
    end
  end

  // the last level always leaves exactly the outputs of the last compressor
  if (LEFT == 0) begin : gNone
    assign sumOut   = '0;
    assign carryOut = '0;
  end else if (NUM_OPS == 0) begin : gPass
    assign sumOut = opExt[FIN0];
    if (LEFT == 2) begin : gPair
      assign carryOut = opExt[FIN1];
    end else begin : gSingle
      assign carryOut = '0;
    end
  end else begin : gTree
    assign sumOut   = gOp[NUM_OPS-1].sumV;
    assign carryOut = gOp[NUM_OPS-1].carV;
  end
endmodule

// File: rtl/cmpr_check.sv
module cmpr_check #(
  parameter int N   = 6,
  parameter int OPW = 8,
  parameter int W   = 12,
  localparam int IN_W = ((N == 0) ? 1 : N) * OPW
) (
  input logic [IN_W-1:0] opIn,
  input logic [W-1:0]    sumOut,
  input logic [W-1:0]    carryOut
);
  logic [W-1:0] total;

  always_comb begin
    total = '0;
    for (int j = 0; j < N; j++) total = total + W'(opIn[j*OPW +: OPW]);
    AST_MOD_SUM: assert (W'(sumOut + carryOut) == total); // R1
  end

  if (N == 0) begin : gEmpty
    always_comb begin
      AST_EMPTY_ZERO: assert (sumOut == '0 && carryOut == '0); // R3
    end
  end else if (N == 1) begin : gSingle
    always_comb begin
      AST_SINGLE_PASS: assert (sumOut == W'(opIn[OPW-1:0]) && carryOut == '0); // R4
    end
  end else if (N == 2) begin : gPair
    always_comb begin
      AST_PAIR_PASS: assert (sumOut == W'(opIn[OPW-1:0]) && carryOut == W'(opIn[2*OPW-1:OPW])); // R5
    end
  end else begin : gTree
    always_comb begin
      AST_CARRY_LSB: assert (carryOut[0] == 1'b0); // R2
    end
  end
endmodule

bind carry_save_reducer cmpr_check #(.N(N), .OPW(OPW), .W(W)) u_check (
  .opIn(opIn), .sumOut(sumOut), .carryOut(carryOut)
);

// File: tb/carry_save_reducer_tb.sv
module carry_save_reducer_tb;
  localparam int OPW  = 5;
  localparam int W    = 7;
  localparam int NMAX = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [NMAX*OPW-1:0] opBus = '0;
  logic [W-1:0]  sumArr [2][NMAX+1];
  logic [W-1:0]  carArr [2][NMAX+1];
  logic [15:0]   rowArr [2][NMAX+1];
  logic [15:0]   depArr [2][NMAX+1];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  for (genvar s = 0; s < 2; s++) begin : gS
    for (genvar n = 0; n <= NMAX; n++) begin : gN
      localparam int IW = ((n == 0) ? 1 : n) * OPW;
      carry_save_reducer #(.N(n), .OPW(OPW), .W(W), .PREFER_42(s == 1)) u_dut (
        .opIn(opBus[IW-1:0]),
        .sumOut(sumArr[s][n]),
        .carryOut(carArr[s][n]),
        .rowCount(rowArr[s][n]),
        .treeDepth(depArr[s][n])
      );
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int opVal(input int j);
    return int'(opBus[j*OPW +: OPW]);
  endfunction

  function automatic int expSum(input int n);
    int t = 0;
    for (int j = 0; j < n; j++) t += opVal(j);
    return t % (1 << W);
  endfunction

  // schedule model on depth lists: returns rows (wantDepth=0) or depth
  function automatic int modelPlan(input int n, input bit use42, input bit wantDepth);
    int d [64];
    int e [64];
    int wv [64];
    int nd [64];
    int cnt, lvl, rows, ne, nw, nn, p, g, mx, res;
    cnt = n; lvl = 0; rows = 0;
    for (int j = 0; j < 64; j++) begin d[j] = 0; e[j] = 0; wv[j] = 0; nd[j] = 0; end
    while (cnt > 2) begin
      ne = 0; nw = 0;
      for (int j = 0; j < cnt; j++)
        if (d[j] <= lvl) begin e[ne] = d[j]; ne++; end
        else begin wv[nw] = d[j]; nw++; end
      if (ne >= 3) begin
        nn = 0; p = 0;
        while (ne - p >= 3) begin
          g = (use42 && (ne - p) >= 4) ? 4 : 3;
          mx = 0;
          for (int j = p; j < p + g; j++) if (e[j] > mx) mx = e[j];
          nd[nn] = mx + g - 2; nd[nn+1] = mx + g - 2; nn += 2;
          rows += g - 2; p += g;
        end
        for (int j = p; j < ne; j++) begin nd[nn] = e[j]; nn++; end
        for (int j = 0; j < nw; j++) begin nd[nn] = wv[j]; nn++; end
        for (int j = 0; j < nn; j++) d[j] = nd[j];
        cnt = nn;
      end
      lvl++;
    end
    if (!wantDepth) res = rows;
    else if (cnt == 0) res = 0;
    else if (cnt == 1) res = d[0];
    else res = (d[0] > d[1]) ? d[0] : d[1];
    return res;
  endfunction

  task automatic checkAll();
    int e, a;
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n <= NMAX; n++) begin
        e = expSum(n);
        a = (int'(sumArr[s][n]) + int'(carArr[s][n])) % (1 << W);
        chk(a == e, "R1", $sformatf("modsum s=%0d n=%0d", s, n), a, e);
        if (n == 0) begin
          chk(sumArr[s][n] == '0 && carArr[s][n] == '0, "R3", "empty outputs",
              int'(sumArr[s][n]) + int'(carArr[s][n]), 0);
        end else if (n == 1) begin
          chk(int'(sumArr[s][n]) == opVal(0), "R4", "single sum", int'(sumArr[s][n]), opVal(0));
          chk(carArr[s][n] == '0, "R4", "single carry", int'(carArr[s][n]), 0);
        end else if (n == 2) begin
          chk(int'(sumArr[s][n]) == opVal(0), "R5", "pair sum", int'(sumArr[s][n]), opVal(0));
          chk(int'(carArr[s][n]) == opVal(1), "R5", "pair carry", int'(carArr[s][n]), opVal(1));
        end else begin
          chk(carArr[s][n][0] == 1'b0, "R2", $sformatf("carry lsb s=%0d n=%0d", s, n),
              int'(carArr[s][n][0]), 0);
        end
      end
    end
  endtask

  task automatic applyAndCheck(input logic [NMAX*OPW-1:0] v);
    @(posedge clk);
    #1 opBus = v;
    @(negedge clk);
    checkAll();
  endtask

  initial begin : main
    logic [NMAX*OPW-1:0] v;
    // idle state with all operands zero
    @(negedge clk);
    for (int s = 0; s < 2; s++)
      for (int n = 0; n <= NMAX; n++)
        chk(sumArr[s][n] == '0 && carArr[s][n] == '0, "R1", "idle zero",
            int'(sumArr[s][n]) + int'(carArr[s][n]), 0);

    // constant figures against the schedule model and hand values
    for (int s = 0; s < 2; s++)
      for (int n = 0; n <= NMAX; n++) begin
        chk(int'(rowArr[s][n]) == modelPlan(n, s == 1, 1'b0), "R6",
            $sformatf("rows s=%0d n=%0d", s, n), int'(rowArr[s][n]), modelPlan(n, s == 1, 1'b0));
        chk(int'(depArr[s][n]) == modelPlan(n, s == 1, 1'b1), "R7",
            $sformatf("depth s=%0d n=%0d", s, n), int'(depArr[s][n]), modelPlan(n, s == 1, 1'b1));
      end
    chk(rowArr[0][4] == 16'd2 && rowArr[1][4] == 16'd2, "R6", "rows n=4", int'(rowArr[1][4]), 2);
    chk(rowArr[0][9] == 16'd7 && rowArr[1][9] == 16'd7, "R6", "rows n=9", int'(rowArr[1][9]), 7);
    chk(depArr[0][3] == 16'd1 && depArr[1][3] == 16'd1, "R7", "depth n=3", int'(depArr[1][3]), 1);
    chk(depArr[0][4] == 16'd2 && depArr[1][4] == 16'd2, "R7", "depth n=4", int'(depArr[0][4]), 2);
    chk(depArr[0][6] == 16'd3, "R8", "depth n=6 plain", int'(depArr[0][6]), 3);
    chk(depArr[1][6] == 16'd4, "R8", "depth n=6 grouped", int'(depArr[1][6]), 4);
    chk(depArr[0][9] == 16'd4, "R8", "depth n=9 plain", int'(depArr[0][9]), 4);
    chk(depArr[1][9] == 16'd5, "R8", "depth n=9 grouped", int'(depArr[1][9]), 5);
    chk(rowArr[1][5] == 16'd3 && depArr[1][5] == 16'd3, "R9", "n=5 grouped rows/depth",
        int'(rowArr[1][5]) * 10 + int'(depArr[1][5]), 33);
    chk(rowArr[1][7] == 16'd5 && depArr[1][7] == 16'd4, "R9", "n=7 grouped rows/depth",
        int'(rowArr[1][7]) * 10 + int'(depArr[1][7]), 54);

    // all ones: maximum wrap
    applyAndCheck('1);
    // walking single set bit across the whole bus
    for (int b = 0; b < NMAX * OPW; b++) begin
      v = '0;
      v[b] = 1'b1;
      applyAndCheck(v);
    end
    // every operand equal, swept over all values
    for (int x = 0; x < (1 << OPW); x++) begin
      v = '0;
      for (int j = 0; j < NMAX; j++) v[j*OPW +: OPW] = OPW'(x);
      applyAndCheck(v);
    end
    // random operand sets
    for (int r = 0; r < 3000; r++) begin
      for (int j = 0; j < NMAX; j++) v[j*OPW +: OPW] = OPW'($urandom);
      applyAndCheck(v);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule